// File: doc/BRIEF.md
# Vectored Interrupt Priority Arbiter

This block sits between a group of interrupt-requesting peripherals and the single interrupt input of a processor. While any peripheral holds its request line high, the block drives the processor interrupt line high. When the processor answers with an acknowledge, the block selects one requester and raises that requester's own acknowledge line. The selected peripheral then drives its interrupt vector onto the system data bus. The grant stays in place until the processor signals that service has ended.

The selection policy can be changed at run time. In fixed mode, each source has a permanent rank. In rotating mode, the search starts from a pointer. That pointer moves past whichever source was served last, so sources that request equally often are served in turn. Requests that are still pending after a completion keep the interrupt line high, and the next acknowledge starts a new service cycle.

Top module: `irq_prio_arbiter`

## Requirements
- R1: `irq_o` is high in the same cycle as any bit of `req_i` is high, and low when all bits are low.
- R2: A service cycle starts at a clock edge where all three of these hold: `inta_i` is sampled high, `inta_i` was low at the previous edge, and the block is idle with a nonzero `req_i`. From the next cycle, exactly one bit of `ack_o` is high, and it belongs to a source that was requesting at that edge.
- R3: With `mode_rotate_i` = 0 (fixed mode), the requesting source with the lowest index wins. Source 0 has the highest rank.
- R4: With `mode_rotate_i` = 1 (rotating mode), the search starts at the rotation pointer and moves to ascending indices, wrapping from N_SRC-1 to 0. The first requesting source found wins.
- R5: When a completion is sampled with `mode_rotate_i` = 1, the pointer becomes (served index + 1) mod N_SRC. A completion sampled in fixed mode leaves the pointer unchanged.
- R6: While a grant is held, `ack_o` stays constant until a completion, regardless of changes on `req_i`, `mode_rotate_i` or `inta_i`.
- R7: `done_i` sampled high while a grant is held clears `ack_o` in the next cycle. `done_i` while idle has no effect.
- R8: An `inta_i` rising edge while `req_i` is zero grants nothing. Holding `inta_i` high does not start a cycle; only a fresh low-to-high edge does.
- R9: While `rst_ni` is low, `ack_o` is zero, the block is idle, and the rotation pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_rotate_i | input | 1 | 0 = fixed rank, 1 = rotating priority |
| req_i | input | N_SRC | Per-source interrupt requests |
| irq_o | output | 1 | Interrupt line to the processor |
| inta_i | input | 1 | Interrupt acknowledge from the processor |
| ack_o | output | N_SRC | One-hot acknowledge to the selected source |
| done_i | input | 1 | End-of-service handshake from the processor |

## Verification
The bench builds the block with N_SRC = 4. With four sources, the rotating pointer wraps from the top source back to source 0 within a few service cycles, and every pointer position is visited often under random requests. This small width also lets directed sequences reach two cases in a handful of steps: a rotating search that has to skip past the pointer, and a fixed-mode completion that must leave the pointer alone. Random mode switches in the middle of service cycles exercise the grant-hold rule against every ordering of requests.

// File: rtl/iarb_pkg.sv
package iarb_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } arb_state_e;
endpackage

// File: rtl/iarb_fixed_pick.sv
// Lowest index wins: a source is blocked if any lower index requests.
module iarb_fixed_pick #(
    parameter int unsigned N_SRC = 4
) (
    input  logic [N_SRC-1:0] req_i,
    output logic [N_SRC-1:0] gnt_o
);
    logic [N_SRC-1:0] blocked;

    assign blocked[0] = 1'b0;
    assign gnt_o[0]   = req_i[0];

    for (genvar i = 1; i < N_SRC; i++) begin : g_chain
        assign blocked[i] = blocked[i-1] | req_i[i-1];
        assign gnt_o[i]   = req_i[i] & ~blocked[i];
    end
endmodule

// File: rtl/iarb_rot_pick.sv
// Search from ptr_i upward with wrap; first requester wins.
module iarb_rot_pick #(
    parameter int unsigned N_SRC = 4,
    parameter int unsigned PW    = 2
) (
    input  logic [N_SRC-1:0] req_i,
    input  logic [PW-1:0]    ptr_i,
    output logic [N_SRC-1:0] gnt_o
);
    always_comb begin
        logic found;
        int   idx;
        found = 1'b0;
        gnt_o = '0;
        for (int k = 0; k < N_SRC; k++) begin
            idx = int'(ptr_i) + k;
            if (idx >= N_SRC) begin
                idx = idx - N_SRC;
            end
            if (!found && req_i[idx]) begin
                gnt_o[idx] = 1'b1;
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/iarb_onehot_idx.sv
// One-hot to index, plus the next rotation pointer after that index.
module iarb_onehot_idx #(
    parameter int unsigned N_SRC = 4,
    parameter int unsigned PW    = 2
) (
    input  logic [N_SRC-1:0] onehot_i,
    output logic [PW-1:0]    next_ptr_o
);
    logic [PW-1:0] idx;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (onehot_i[i]) begin
                idx = idx | PW'(i);
            end
        end
        if (idx == PW'(N_SRC - 1)) begin
            next_ptr_o = '0;
        end else begin
            next_ptr_o = idx + PW'(1);
        end
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import iarb_pkg::*;
#(
    parameter int unsigned N_SRC = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             mode_rotate_i,
    input  logic [N_SRC-1:0] req_i,
    output logic             irq_o,
    input  logic             inta_i,
    output logic [N_SRC-1:0] ack_o,
    input  logic             done_i
);
    localparam int unsigned PW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    typedef struct packed {
        arb_state_e       st;
        logic             inta;
        logic [N_SRC-1:0] grant;
        logic [PW-1:0]    ptr;
    } arb_regs_t;

    arb_regs_t r_d, r_q;

    logic [N_SRC-1:0] fix_gnt;
    logic [N_SRC-1:0] rot_gnt;
    logic [PW-1:0]    next_ptr;

    iarb_fixed_pick #(.N_SRC(N_SRC)) u_fix (
        .req_i (req_i),
        .gnt_o (fix_gnt)
    );

    iarb_rot_pick #(.N_SRC(N_SRC), .PW(PW)) u_rot (
        .req_i (req_i),
        .ptr_i (r_q.ptr),
        .gnt_o (rot_gnt)
    );

    iarb_onehot_idx #(.N_SRC(N_SRC), .PW(PW)) u_idx (
        .onehot_i   (r_q.grant),
        .next_ptr_o (next_ptr)
    );

    always_comb begin
        r_d      = r_q;
        r_d.inta = inta_i;
        unique case (r_q.st)
            ST_IDLE: begin
                // start only on a fresh acknowledge edge with work pending
                if (inta_i && !r_q.inta && (|req_i)) begin
                    r_d.st    = ST_SERVE;
                    r_d.grant = mode_rotate_i ? rot_gnt : fix_gnt;
                end
            end
            ST_SERVE: begin
                if (done_i) begin
                    r_d.st    = ST_IDLE;
                    r_d.grant = '0;
                    if (mode_rotate_i) begin
                        r_d.ptr = next_ptr;
                    end
                end
            end
            default: r_d = r_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{st: ST_IDLE, inta: 1'b0, grant: '0, ptr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign irq_o = |req_i;
    assign ack_o = r_q.grant;
endmodule

// File: rtl/iarb_checker.sv
module iarb_checker #(
    parameter int unsigned N_SRC = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [N_SRC-1:0] req_i,
    input logic             irq_o,
    input logic             inta_i,
    input logic [N_SRC-1:0] ack_o,
    input logic             done_i
);
    assert_irq_any_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o == (req_i != '0));

    assert_ack_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(ack_o));

    assert_ack_after_inta_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(|ack_o) |-> ($past(inta_i) && (($past(req_i) & ack_o) != '0)));

    assert_ack_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|ack_o) && !done_i) |=> (ack_o == $past(ack_o)));

    assert_done_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((|ack_o) && done_i) |=> (ack_o == '0));

    assert_reset_idle_R9: assert property (@(posedge clk_i)
        !rst_ni |-> (ack_o == '0));
endmodule

bind irq_prio_arbiter iarb_checker #(.N_SRC(N_SRC)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .irq_o  (irq_o),
    .inta_i (inta_i),
    .ack_o  (ack_o),
    .done_i (done_i)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
    localparam int N       = 4;
    localparam int CLK_PER = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode = 1'b0;
    logic [N-1:0] req = '0;
    logic         irq;
    logic         inta = 1'b0;
    logic [N-1:0] ack;
    logic         done = 1'b0;

    int total = 0;
    int bad   = 0;

    // reference model state
    bit m_serve = 0;
    int m_g     = 0;
    int m_ptr   = 0;
    bit m_inta  = 0;

    always #(CLK_PER/2) clk = ~clk;

    irq_prio_arbiter #(.N_SRC(N)) u_irq_prio_arbiter (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .mode_rotate_i (mode),
        .req_i         (req),
        .irq_o         (irq),
        .inta_i        (inta),
        .ack_o         (ack),
        .done_i        (done)
    );

    function automatic int pick(input logic [N-1:0] r, input bit rot, input int p);
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = rot ? (p + k) % N : k;
            if (r[idx]) return idx;
        end
        return 0;
    endfunction

    function automatic logic [N-1:0] model_ack();
        return m_serve ? (N'(1) << m_g) : '0;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        if (m_serve) begin
            if (done) begin
                m_serve = 0;
                if (mode) m_ptr = (m_g + 1) % N;
            end
        end else if (inta && !m_inta && (req != '0)) begin
            m_serve = 1;
            m_g     = pick(req, mode, m_ptr);
        end
        m_inta = inta;
    endtask

    task automatic step(input logic [N-1:0] rq, input logic md, input logic ia,
                        input logic dn, input string tag);
        @(negedge clk);
        req = rq; mode = md; inta = ia; done = dn;
        #1;
        chk(irq === (rq != '0), {tag, " R1 irq"}, 32'(irq), 32'(rq != '0));
        @(posedge clk);
        model_edge();
        #1;
        chk(ack === model_ack(), {tag, " ack"}, 32'(ack), 32'(model_ack()));
    endtask

    task automatic lit(input logic [N-1:0] exp, input string tag);
        chk(ack === exp, tag, 32'(ack), 32'(exp));
    endtask

    initial begin
        #(CLK_PER * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        #(CLK_PER * 2 + 1);
        chk(ack === '0, "R9 ack in reset", 32'(ack), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(ack === '0, "R9 ack after reset", 32'(ack), 0);

        // R3 fixed rank
        step(4'b1010, 0, 1, 0, "R3");            lit(4'b0010, "R3 lowest index wins");
        // R6 hold through changes
        step(4'b0101, 1, 0, 0, "R6");            lit(4'b0010, "R6 hold req/mode change");
        step(4'b0000, 1, 1, 0, "R6");            lit(4'b0010, "R6 hold inta edge");
        // R7 completion and idle done
        step(4'b0000, 0, 0, 1, "R7");            lit(4'b0000, "R7 done clears");
        step(4'b0000, 0, 0, 1, "R7 idle");      lit(4'b0000, "R7 idle done ignored");
        // R4/R5 rotation
        step(4'b1010, 1, 1, 0, "R4");            lit(4'b0010, "R4 search from ptr 0");
        step(4'b1010, 1, 0, 1, "R5");
        step(4'b1010, 1, 1, 0, "R5");            lit(4'b1000, "R5 ptr moved to 2");
        step(4'b0000, 1, 0, 1, "R5");
        step(4'b1111, 1, 1, 0, "R4 wrap");       lit(4'b0001, "R4 wrap to 0");
        step(4'b1111, 1, 0, 1, "R5");
        step(4'b1111, 0, 1, 0, "R3");            lit(4'b0001, "R3 fixed ignores ptr");
        step(4'b1111, 0, 0, 1, "R5 fixed done");
        step(4'b1001, 1, 1, 0, "R5");            lit(4'b1000, "R5 fixed done kept ptr 1");
        step(4'b0000, 1, 0, 1, "R7");
        // R8 no request, held acknowledge
        step(4'b0000, 0, 1, 0, "R8");            lit(4'b0000, "R8 no request no grant");
        step(4'b0100, 0, 1, 0, "R8 held");       lit(4'b0000, "R8 held inta no start");
        step(4'b0100, 0, 0, 0, "R8");
        step(4'b0100, 0, 1, 0, "R2");            lit(4'b0100, "R2 fresh edge grants");
        step(4'b0000, 0, 0, 1, "R7");

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [N-1:0] rq;
            logic md, ia, dn;
            rq = N'($urandom_range(0, (1 << N) - 1));
            md = 1'($urandom_range(0, 1));
            ia = ($urandom_range(0, 2) == 0);
            dn = ($urandom_range(0, 3) == 0);
            step(rq, md, ia, dn, "R2 R4 R5 R6 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule